// File: doc/BRIEF.md
# Bit-Reversed FFT Address Generator

This block computes write addresses for reordering radix-2 FFT data into bit-reversed order. Each request gives the block a pointer register value and the index of that register. It also gives an enable bit, a 15-bit pivot modifier, an addressing mode and an access size. The block returns a byte effective address, the value to write back to the pointer, and a flag that tells whether the reversed path produced them. All three outputs are registered and appear one cycle after the request.

The reversed path is taken only when all of these hold: the enable bit is set, the register index is not the stack pointer index, the mode is register indirect with pre-increment or post-increment, the access is a write, and the size is word. In this path the pivot (a word count, normally half the FFT length) is added to the pointer's word index with the carry running from the most significant bit toward the least significant bit. The normal mode increment is not used. When any condition fails, the block produces ordinary register-indirect addresses. The reversed path overrides any modulo correction on the write side, so the block carries no modulo logic.

Top module: `brev_agen`

## Requirements
- R1: While rst_n is low, and after its release until the first request, out_valid, eff_addr, ptr_next and rev_used are all zero.
- R2: rev_used is 1 exactly when the request had rev_en=1, ptr_sel not equal to 15, mode pre-increment (4) or post-increment (2), is_write=1 and is_byte=0.
- R3: On the reversed path with post-increment, eff_addr is ptr_in with bit 0 cleared. ptr_next is {S,0}, where S = rev(rev(ptr_in[15:1]) + rev(pivot)) over 15 bits.
- R4: On the reversed path with pre-increment, eff_addr and ptr_next both equal {S,0}, with S as in R3.
- R5: On the reversed path, bit 0 of eff_addr and of ptr_next is 0 even when ptr_in is odd.
- R6: Otherwise the normal path is used with step 1 for byte and 2 for word. Mode 2 (post-inc) gives eff_addr=ptr, next=ptr+step. Mode 4 (pre-inc) gives both equal to ptr+step. Mode 1 (post-dec) gives eff_addr=ptr, next=ptr-step. Mode 3 (pre-dec) gives both equal to ptr-step. Modes 0, 5, 6 and 7 give eff_addr=ptr and next=ptr. All results wrap modulo 2^16.
- R7: For an 8-point buffer at address 0 with pivot 4, feeding ptr_next back as ptr_in on post-increment word writes visits word indices 0,4,2,6,1,5,3,7.
- R8: out_valid equals req_valid delayed by one clock.
- R9: A carry out of the least significant word-index bit during the reversed add is discarded. For example, word index 7 plus pivot 4 gives index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| rev_en | input | 1 | Bit-reversed addressing enable |
| ptr_sel | input | 4 | Index of the pointer register |
| pivot | input | 15 | Pivot modifier in words |
| ptr_in | input | 16 | Current pointer value (byte address) |
| mode | input | 3 | Addressing mode code |
| is_write | input | 1 | 1 for a write access |
| is_byte | input | 1 | 1 for a byte access, 0 for a word access |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 16 | Effective byte address |
| ptr_next | output | 16 | Pointer write-back value |
| rev_used | output | 1 | Reversed path produced the result |

## Verification
The assertions assume that the request inputs are settled before each rising edge. They also assume that rev_en, ptr_sel, mode, is_write and is_byte hold their values for the whole cycle in which req_valid is high. The bench drives every input on the falling edge, so each request stays stable through the capturing edge. The reversed-path checks assume that buffers are aligned to their size. For that reason, the R7 and R9 cases start the pointer at a 16-byte-aligned base.

// File: rtl/brev_pkg.sv
package brev_pkg;
    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTDEC = 3'd1,
        AM_POSTINC = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_PREINC  = 3'd4
    } amode_e;
endpackage

// File: rtl/brev_qualify.sv
module brev_qualify #(
    parameter int SELW   = 4,
    parameter int SP_IDX = 15
) (
    input  logic            en,
    input  logic [SELW-1:0] sel,
    input  logic [2:0]      mode,
    input  logic            is_write,
    input  logic            is_byte,
    output logic            active
);
    import brev_pkg::*;
    logic mode_ok;
    logic sel_ok;

    always_comb begin
        mode_ok = (mode == AM_POSTINC) || (mode == AM_PREINC);
        sel_ok  = (sel != SELW'(SP_IDX));
        active  = en && sel_ok && mode_ok && is_write && !is_byte;
    end
endmodule

// File: rtl/brev_rcadd.sv
module brev_rcadd #(
    parameter int IW = 15
) (
    input  logic [IW-1:0] a,
    input  logic [IW-1:0] b,
    output logic [IW-1:0] sum
);
    logic [IW-1:0] a_r;
    logic [IW-1:0] b_r;
    logic [IW-1:0] s_r;

    // mirror operands, add with ordinary carry, mirror back
    for (genvar i = 0; i < IW; i++) begin : g_mirror
        assign a_r[i] = a[IW-1-i];
        assign b_r[i] = b[IW-1-i];
        assign sum[i] = s_r[IW-1-i];
    end

    assign s_r = a_r + b_r;
endmodule

// File: rtl/norm_agen.sv
module norm_agen #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic [2:0]    mode,
    input  logic          is_byte,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] nxt
);
    import brev_pkg::*;
    logic [AW-1:0] step;
    logic [AW-1:0] up;
    logic [AW-1:0] dn;

    always_comb begin
        step = is_byte ? AW'(1) : AW'(2);
        up   = ptr + step;
        dn   = ptr - step;
        ea   = ptr;
        nxt  = ptr;
        case (mode)
            AM_POSTINC: nxt = up;
            AM_POSTDEC: nxt = dn;
            AM_PREINC: begin
                ea  = up;
                nxt = up;
            end
            AM_PREDEC: begin
                ea  = dn;
                nxt = dn;
            end
            default: begin
                ea  = ptr;
                nxt = ptr;
            end
        endcase
    end
endmodule

// File: rtl/brev_agen.sv
module brev_agen #(
    parameter int AW     = 16,
    parameter int SELW   = 4,
    parameter int SP_IDX = 15,
    localparam int IW    = AW - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            rev_en,
    input  logic [SELW-1:0] ptr_sel,
    input  logic [IW-1:0]   pivot,
    input  logic [AW-1:0]   ptr_in,
    input  logic [2:0]      mode,
    input  logic            is_write,
    input  logic            is_byte,
    output logic            out_valid,
    output logic [AW-1:0]   eff_addr,
    output logic [AW-1:0]   ptr_next,
    output logic            rev_used
);
    import brev_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] ea;
        logic [AW-1:0] nxt;
        logic          used;
    } res_t;

    res_t r_d;
    res_t r_q;

    logic          rev_act;
    logic [IW-1:0] rev_sum;
    logic [AW-1:0] n_ea;
    logic [AW-1:0] n_nxt;

    brev_qualify #(.SELW(SELW), .SP_IDX(SP_IDX)) u_qual (
        .en       (rev_en),
        .sel      (ptr_sel),
        .mode     (mode),
        .is_write (is_write),
        .is_byte  (is_byte),
        .active   (rev_act)
    );

    brev_rcadd #(.IW(IW)) u_rcadd (
        .a   (ptr_in[AW-1:1]),
        .b   (pivot),
        .sum (rev_sum)
    );

    norm_agen #(.AW(AW)) u_norm (
        .ptr     (ptr_in),
        .mode    (mode),
        .is_byte (is_byte),
        .ea      (n_ea),
        .nxt     (n_nxt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = req_valid;
        if (req_valid) begin
            if (rev_act) begin
                r_d.used = 1'b1;
                r_d.nxt  = {rev_sum, 1'b0};
                r_d.ea   = (mode == AM_PREINC) ? {rev_sum, 1'b0}
                                               : {ptr_in[AW-1:1], 1'b0};
            end else begin
                r_d.used = 1'b0;
                r_d.nxt  = n_nxt;
                r_d.ea   = n_ea;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid = r_q.vld;
    assign eff_addr  = r_q.ea;
    assign ptr_next  = r_q.nxt;
    assign rev_used  = r_q.used;
endmodule

module brev_agen_chk #(
    parameter int AW   = 16,
    parameter int SELW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [SELW-1:0] ptr_sel,
    input logic [AW-1:0]   ptr_in,
    input logic [2:0]      mode,
    input logic            is_write,
    input logic            is_byte,
    input logic            out_valid,
    input logic [AW-1:0]   eff_addr,
    input logic [AW-1:0]   ptr_next,
    input logic            rev_used
);
    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R5
    rev_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rev_used |-> (eff_addr[0] == 1'b0 && ptr_next[0] == 1'b0));
    // R2
    byte_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_byte) |=> !rev_used);
    // R2
    read_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_write) |=> !rev_used);
    // R2
    stack_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ptr_sel == SELW'(15)) |=> !rev_used);
    // R3
    post_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd2) |=>
            (!rev_used || eff_addr == {$past(ptr_in[AW-1:1]), 1'b0}));
    // R4
    pre_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 3'd4) |=> (!rev_used || eff_addr == ptr_next));
endmodule

bind brev_agen brev_agen_chk #(.AW(AW), .SELW(SELW)) u_chk (.*);

// File: tb/tb_brev_agen.sv
module tb_brev_agen;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int IW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          rev_en = 1'b0;
    logic [3:0]    ptr_sel = '0;
    logic [IW-1:0] pivot = '0;
    logic [AW-1:0] ptr_in = '0;
    logic [2:0]    mode = '0;
    logic          is_write = 1'b0;
    logic          is_byte = 1'b0;
    logic          out_valid;
    logic [AW-1:0] eff_addr;
    logic [AW-1:0] ptr_next;
    logic          rev_used;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [AW-1:0] ea;
        logic [AW-1:0] nxt;
        logic          used;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    brev_agen dut (.*);

    function automatic logic [IW-1:0] rc_add(logic [IW-1:0] a, logic [IW-1:0] b);
        logic [IW-1:0] s;
        logic c;
        c = 1'b0;
        for (int i = IW-1; i >= 0; i--) begin
            s[i] = a[i] ^ b[i] ^ c;
            c = (a[i] & b[i]) | (a[i] & c) | (b[i] & c);
        end
        return s;
    endfunction

    function automatic exp_t model(logic en, logic [3:0] sel, logic [IW-1:0] pv,
                                   logic [AW-1:0] p, logic [2:0] md, logic wr,
                                   logic by, string tag);
        exp_t e;
        logic [AW-1:0] st;
        e.tag = tag;
        if (en && sel != 4'd15 && (md == 3'd2 || md == 3'd4) && wr && !by) begin
            e.used = 1'b1;
            e.nxt = {rc_add(p[AW-1:1], pv), 1'b0};
            e.ea = (md == 3'd4) ? e.nxt : {p[AW-1:1], 1'b0};
        end else begin
            e.used = 1'b0;
            st = by ? 16'd1 : 16'd2;
            case (md)
                3'd1: begin e.ea = p; e.nxt = p - st; end
                3'd2: begin e.ea = p; e.nxt = p + st; end
                3'd3: begin e.ea = p - st; e.nxt = p - st; end
                3'd4: begin e.ea = p + st; e.nxt = p + st; end
                default: begin e.ea = p; e.nxt = p; end
            endcase
        end
        return e;
    endfunction

    task automatic drive(logic en, logic [3:0] sel, logic [IW-1:0] pv,
                         logic [AW-1:0] p, logic [2:0] md, logic wr,
                         logic by, string tag);
        @(negedge clk);
        req_valid = 1'b1; rev_en = en; ptr_sel = sel; pivot = pv;
        ptr_in = p; mode = md; is_write = wr; is_byte = by;
        sb.push_back(model(en, sel, pv, p, md, wr, by, tag));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per valid result
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check("R8 unexpected valid", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " ea"}, eff_addr, e.ea);
                check({e.tag, " next"}, ptr_next, e.nxt);
                check({e.tag, " used"}, {15'd0, rev_used}, {15'd0, e.used});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        check("watchdog", 16'd1, 16'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] p;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {15'd0, out_valid}, 16'd0);
        check("R1 ea", eff_addr, 16'd0);
        check("R1 next", ptr_next, 16'd0);
        check("R1 used", {15'd0, rev_used}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {15'd0, out_valid}, 16'd0);

        // R2 R3 reversed post-increment
        drive(1, 4'd3, 15'd4, 16'h0100, 3'd2, 1, 0, "R3 post");
        drive(1, 4'd3, 15'h0123, 16'h1A2C, 3'd2, 1, 0, "R3 post mix");
        // R4 pre-increment
        drive(1, 4'd2, 15'd8, 16'h0208, 3'd4, 1, 0, "R4 pre");
        // R5 odd pointer
        drive(1, 4'd1, 15'd4, 16'h0105, 3'd2, 1, 0, "R5 odd post");
        drive(1, 4'd1, 15'd2, 16'h0103, 3'd4, 1, 0, "R5 odd pre");
        // R9 carry discarded
        drive(1, 4'd4, 15'd4, 16'h030E, 3'd2, 1, 0, "R9 wrap");
        // R6 fallbacks
        drive(1, 4'd3, 15'd4, 16'h0100, 3'd2, 1, 1, "R6 byte postinc");
        drive(1, 4'd3, 15'd4, 16'h0100, 3'd4, 0, 0, "R6 read preinc");
        drive(1, 4'd15, 15'd4, 16'h0100, 3'd2, 1, 0, "R6 stack");
        drive(0, 4'd3, 15'd4, 16'h0100, 3'd2, 1, 0, "R6 disabled");
        drive(1, 4'd3, 15'd4, 16'h0100, 3'd1, 1, 0, "R6 postdec");
        drive(1, 4'd3, 15'd4, 16'h0000, 3'd3, 1, 1, "R6 predec byte wrap");
        drive(1, 4'd3, 15'd4, 16'hFFFF, 3'd4, 1, 1, "R6 preinc byte wrap");
        drive(1, 4'd3, 15'd4, 16'h0100, 3'd0, 1, 0, "R6 plain");
        drive(1, 4'd3, 15'd4, 16'h0100, 3'd5, 1, 0, "R6 mode5");
        // R7 8-point sequence, base 0x0400
        p = 16'h0400;
        for (int k = 0; k < 8; k++) begin
            int exp_idx [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
            check("R7 index", (p - 16'h0400) >> 1, 16'(exp_idx[k]));
            drive(1, 4'd5, 15'd4, p, 3'd2, 1, 0, "R7 seq");
            p = {rc_add(p[AW-1:1], 15'd4), 1'b0};
        end
        // R8 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; rev_en = 1; ptr_sel = 4'd6; pivot = 15'd2;
        ptr_in = 16'h0500; mode = 3'd2; is_write = 1; is_byte = 0;
        sb.push_back(model(1, 4'd6, 15'd2, 16'h0500, 3'd2, 1, 0, "R8 b2b a"));
        @(negedge clk);
        ptr_in = 16'h0504;
        sb.push_back(model(1, 4'd6, 15'd2, 16'h0504, 3'd2, 1, 0, "R8 b2b b"));
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 drained", 16'(sb.size()), 16'd0);
        check("R8 idle", {15'd0, out_valid}, 16'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule